// File: doc/BRIEF.md
# Grouped-Priority Interrupt Controller

This block gathers twenty-four on-chip request lines, eight off-chip request lines and two machine-check lines. It turns them into the interrupt signals seen by a processor core, plus one interrupt line toward a host. Every ordinary source has an enable bit. Each enabled, pending source goes to one destination, chosen by configuration: the host line, the core's normal interrupt, or a critical or system-management interrupt if it has been promoted. One source picked by software can be lifted above everything else as a critical or system-management request. Machine checks ignore the enables.

The thirty-two sources fall into four groups of eight. Groups 0 and 1 each mix four on-chip and four off-chip lines. Groups 2 and 3 hold on-chip lines only. Each group chooses a grouped or a spread ordering. The normal requests then pass through a priority search, and the winner is reported as a vector number. All outputs are registered, so they follow the inputs one clock later. Configuration is written through a small word-wide write port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A source whose enable bit (address 0, bit s; reset value 0) is clear produces no output of any kind, even when it is the selected top source.
- R2: While the core is enabled, `core_mchk_o` is high one cycle after either machine-check input is high, whatever the enable bits hold.
- R3: An enabled pending source whose route bit (address 1, bit s) is set drives `host_irq_o` and none of the core outputs.
- R4: Source numbering is: s0..3 = on-chip 0..3, s4..7 = off-chip 0..3, s8..11 = on-chip 4..7, s12..15 = off-chip 4..7, s16..23 = on-chip 8..15, s24..31 = on-chip 16..23. Group g holds s = 8g..8g+7 and member m = s mod 8. `vec_o` equals s+1 for the winning normal source, and 0 when there is none.
- R5: Groups 0 and 1 outrank groups 2 and 3. When a group's scheme bit (address 2, bit g) is 0 (grouped), its members take rank m if g is even and rank 8+m if g is odd. A lower rank wins.
- R6: When a group's scheme bit is 1 (spread), its members take rank 2m+(g mod 2). On equal ranks, the even group wins.
- R7: Members 0 and 1 of group g use a 2-bit code at address 3, bits [4g+2m+1:4g+2m]. Code 01 sends the source to `core_cint_o`, code 10 sends it to `core_smi_o`, and codes 00 and 11 leave it normal. A promoted source never sets `vec_o`.
- R8: The word at address 4 holds the top-source index in bits [4:0], an enable in bit 5, and the type in bit 6 (0 = critical, 1 = system-management). When this source is enabled and pending, it drives only that output, overriding route and promotion.
- R9: When bit 0 at address 5 is 0 (reset value 1), every core output and `vec_o` are low, while host-routed sources still drive `host_irq_o`.
- R10: Outputs are levels. Each one reflects the inputs and configuration of the previous cycle and drops one cycle after its last contributing source drops.
- R11: After reset, all outputs are low and all sources are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_int_i | input | 24 | On-chip request lines |
| irq_ext_i | input | 8 | Off-chip request lines |
| mchk_int_i | input | 1 | On-chip machine-check condition |
| mchk_ext_i | input | 1 | Off-chip machine-check condition |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration word address |
| cfg_wdata_i | input | 32 | Configuration write data |
| core_irq_o | output | 1 | Normal interrupt to the core |
| core_cint_o | output | 1 | Critical interrupt to the core |
| core_smi_o | output | 1 | System-management interrupt to the core |
| core_mchk_o | output | 1 | Machine-check to the core |
| host_irq_o | output | 1 | Interrupt line toward the host |
| vec_o | output | 6 | Vector of the winning normal source, 0 when none |

## Verification
The assertions check on every cycle that an all-disabled configuration keeps every request output silent, that machine checks get through while the core is enabled, and that a disabled core keeps all core outputs low. They also check that the vector is zero exactly when no normal interrupt is raised, and that it stays in range. Only the bench's scenarios can show that the correct source wins under each combination of grouped and spread ordering, how ties are broken between sibling groups, and that promotion codes, host routing and the top-source override send each request to the right output.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned N_GRP   = 4;
  localparam int unsigned GRP_SZ  = 8;
  localparam int unsigned N_SRC   = N_GRP * GRP_SZ;
  localparam int unsigned N_INT   = 24;
  localparam int unsigned N_EXT   = 8;
  localparam int unsigned IDX_W   = $clog2(N_SRC);
  localparam int unsigned VEC_W   = IDX_W + 1;
  localparam int unsigned RANK_W  = $clog2(2 * GRP_SZ);
  localparam int unsigned KEY_W   = RANK_W + 2;
  localparam int unsigned PROMO_W = N_GRP * 4;
  localparam int unsigned TOP_W   = IDX_W + 2;

  typedef enum logic [1:0] {
    PR_NORMAL = 2'b00,
    PR_CRIT   = 2'b01,
    PR_SMI    = 2'b10,
    PR_RSVD   = 2'b11
  } promo_e;
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
#(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [N_SRC-1:0]     enable_o,
  output logic [N_SRC-1:0]     route_o,
  output logic [N_GRP-1:0]     spread_o,
  output logic [PROMO_W-1:0]   promo_o,
  output logic [TOP_W-1:0]     top_o,
  output logic                 core_en_o
);
  logic [N_SRC-1:0]   enable_d, route_d;
  logic [N_GRP-1:0]   spread_d;
  logic [PROMO_W-1:0] promo_d;
  logic [TOP_W-1:0]   top_d;
  logic               core_en_d;

  always_comb begin
    enable_d  = enable_o;
    route_d   = route_o;
    spread_d  = spread_o;
    promo_d   = promo_o;
    top_d     = top_o;
    core_en_d = core_en_o;
    if (we_i) begin
      unique case (addr_i)
        AW'(0): enable_d  = wdata_i[N_SRC-1:0];
        AW'(1): route_d   = wdata_i[N_SRC-1:0];
        AW'(2): spread_d  = wdata_i[N_GRP-1:0];
        AW'(3): promo_d   = wdata_i[PROMO_W-1:0];
        AW'(4): top_d     = wdata_i[TOP_W-1:0];
        AW'(5): core_en_d = wdata_i[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_o  <= '0;
      route_o   <= '0;
      spread_o  <= '0;
      promo_o   <= '0;
      top_o     <= '0;
      core_en_o <= 1'b1;
    end else if (we_i) begin
      enable_o  <= enable_d;
      route_o   <= route_d;
      spread_o  <= spread_d;
      promo_o   <= promo_d;
      top_o     <= top_d;
      core_en_o <= core_en_d;
    end
  end
endmodule

// File: rtl/pic_rank_gen.sv
module pic_rank_gen
  import pic_pkg::*;
(
  input  logic [N_GRP-1:0]            spread_i,
  output logic [N_SRC-1:0][KEY_W-1:0] key_o
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam logic ODD  = (g % 2) == 1;
    localparam logic LOW  = (g / 2) == 1;
    for (genvar m = 0; m < GRP_SZ; m++) begin : g_mem
      localparam logic [RANK_W-1:0] R_GRP = RANK_W'((g % 2) * GRP_SZ + m);
      localparam logic [RANK_W-1:0] R_SPR = RANK_W'(2 * m + (g % 2));
      assign key_o[g*GRP_SZ+m] = spread_i[g] ? {LOW, R_SPR, ODD}
                                             : {LOW, R_GRP, ODD};
    end
  end
endmodule

// File: rtl/pic_select.sv
module pic_select
  import pic_pkg::*;
(
  input  logic [N_SRC-1:0]            elig_i,
  input  logic [N_SRC-1:0][KEY_W-1:0] key_i,
  output logic                        found_o,
  output logic [IDX_W-1:0]            idx_o
);
  logic [KEY_W-1:0] best;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    for (int s = 0; s < N_SRC; s++) begin
      if (elig_i[s] && (!found_o || key_i[s] < best)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(s);
        best    = key_i[s];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned CFG_AW = 3,
  parameter int unsigned CFG_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_INT-1:0]  irq_int_i,
  input  logic [N_EXT-1:0]  irq_ext_i,
  input  logic              mchk_int_i,
  input  logic              mchk_ext_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  output logic              core_irq_o,
  output logic              core_cint_o,
  output logic              core_smi_o,
  output logic              core_mchk_o,
  output logic              host_irq_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [1:0] rst_sync;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  logic [N_SRC-1:0]            enable, route;
  logic [N_GRP-1:0]            spread;
  logic [PROMO_W-1:0]          promo;
  logic [TOP_W-1:0]            top;
  logic                        core_en;
  logic [N_SRC-1:0][KEY_W-1:0] key;

  pic_cfg_regs #(.AW(CFG_AW), .DW(CFG_DW)) i_cfg (
    .clk(clk), .rst_n(rst_s_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .enable_o(enable), .route_o(route),
    .spread_o(spread), .promo_o(promo), .top_o(top), .core_en_o(core_en)
  );

  pic_rank_gen i_rank (.spread_i(spread), .key_o(key));

  logic [N_SRC-1:0] src, live, elig_n, elig_c, elig_s, elig_h;
  logic [IDX_W-1:0] top_idx, win_idx;
  logic             top_on, top_smi, top_hit, win_found;

  assign src = {irq_int_i[23:8], irq_ext_i[7:4], irq_int_i[7:4],
                irq_ext_i[3:0], irq_int_i[3:0]};
  assign live    = src & enable;
  assign top_idx = top[IDX_W-1:0];
  assign top_on  = top[IDX_W];
  assign top_smi = top[IDX_W+1];
  assign top_hit = top_on && live[top_idx];

  always_comb begin
    elig_n = '0;
    elig_c = '0;
    elig_s = '0;
    elig_h = '0;
    for (int s = 0; s < N_SRC; s++) begin
      promo_e code;
      code = PR_NORMAL;
      if ((s % GRP_SZ) < 2)
        code = promo_e'(promo[(s / GRP_SZ) * 4 + (s % GRP_SZ) * 2 +: 2]);
      if (live[s] && !(top_on && top_idx == IDX_W'(s))) begin
        if (route[s])              elig_h[s] = 1'b1;
        else if (code == PR_CRIT)  elig_c[s] = 1'b1;
        else if (code == PR_SMI)   elig_s[s] = 1'b1;
        else                       elig_n[s] = 1'b1;
      end
    end
  end

  pic_select i_sel (.elig_i(elig_n), .key_i(key),
                    .found_o(win_found), .idx_o(win_idx));

  logic             irq_d, cint_d, smi_d, mchk_d, host_d;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    irq_d  = core_en && (|elig_n);
    cint_d = core_en && ((|elig_c) || (top_hit && !top_smi));
    smi_d  = core_en && ((|elig_s) || (top_hit && top_smi));
    mchk_d = core_en && (mchk_int_i || mchk_ext_i);
    host_d = |elig_h;
    vec_d  = (core_en && win_found) ? VEC_W'(win_idx) + VEC_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      core_irq_o  <= 1'b0;
      core_cint_o <= 1'b0;
      core_smi_o  <= 1'b0;
      core_mchk_o <= 1'b0;
      host_irq_o  <= 1'b0;
      vec_o       <= '0;
    end else begin
      core_irq_o  <= irq_d;
      core_cint_o <= cint_d;
      core_smi_o  <= smi_d;
      core_mchk_o <= mchk_d;
      host_irq_o  <= host_d;
      vec_o       <= vec_d;
    end
  end

  // R1: nothing enabled means nothing raised on the next cycle
  a_r1_all_disabled_silent: assert property (@(posedge clk) disable iff (!rst_s_n)
    (enable == '0) |=> !core_irq_o && !core_cint_o && !core_smi_o && !host_irq_o);

  // R2: machine check passes regardless of enables
  a_r2_mchk_passes: assert property (@(posedge clk) disable iff (!rst_s_n)
    (core_en && (mchk_int_i || mchk_ext_i)) |=> core_mchk_o);

  // R9: disabled core silences every core output
  a_r9_core_off: assert property (@(posedge clk) disable iff (!rst_s_n)
    !core_en |=> !core_irq_o && !core_cint_o && !core_smi_o && !core_mchk_o
                 && vec_o == '0);

  // R4: vector is nonzero exactly when a normal interrupt is raised
  a_r4_vec_matches_irq: assert property (@(posedge clk) disable iff (!rst_s_n)
    core_irq_o == (vec_o != '0));

  // R4: vector stays within the source range
  a_r4_vec_range: assert property (@(posedge clk) disable iff (!rst_s_n)
    vec_o <= VEC_W'(N_SRC));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] irq_int;
  logic [7:0]  irq_ext;
  logic        mchk_int, mchk_ext;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        core_irq, core_cint, core_smi, core_mchk, host_irq;
  logic [5:0]  vec;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_int_i(irq_int), .irq_ext_i(irq_ext),
    .mchk_int_i(mchk_int), .mchk_ext_i(mchk_ext), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .core_irq_o(core_irq),
    .core_cint_o(core_cint), .core_smi_o(core_smi), .core_mchk_o(core_mchk),
    .host_irq_o(host_irq), .vec_o(vec)
  );

  typedef struct packed {
    logic [31:0] en;
    logic [31:0] rt;
    logic [3:0]  sch;
    logic [15:0] pr;
    logic [6:0]  top;
    logic [23:0] ii;
    logic [7:0]  ie;
    logic [9:0]  exp;   // {irq, cint, smi, host, vec[5:0]}
  } row_t;

  localparam int NROWS = 14;
  localparam row_t TBL [NROWS] = '{
    '{32'hFFFFFFFF, 32'h0, 4'h0, 16'h0,    7'h00, 24'h000001, 8'h00, {4'b1000, 6'd1}},  // R4 s0
    '{32'hFFFFFFFF, 32'h0, 4'h0, 16'h0,    7'h00, 24'h800000, 8'h00, {4'b1000, 6'd32}}, // R4 s31
    '{32'hFFFFFFFF, 32'h0, 4'h0, 16'h0,    7'h00, 24'h008000, 8'h01, {4'b1000, 6'd5}},  // R5 pair order
    '{32'hFFFFFFFF, 32'h0, 4'h0, 16'h0,    7'h00, 24'h000010, 8'h08, {4'b1000, 6'd8}},  // R5 grouped
    '{32'hFFFFFFFF, 32'h0, 4'h3, 16'h0,    7'h00, 24'h000010, 8'h08, {4'b1000, 6'd9}},  // R6 spread
    '{32'hFFFFFFFF, 32'h0, 4'h3, 16'h0,    7'h00, 24'h000012, 8'h00, {4'b1000, 6'd9}},  // R6 interleave
    '{32'hFFFFFFFF, 32'h0, 4'hC, 16'h0,    7'h00, 24'h010200, 8'h00, {4'b1000, 6'd25}}, // R6 pair 1
    '{32'hFFFFFFFE, 32'h0, 4'h0, 16'h0,    7'h00, 24'h000001, 8'h00, {4'b0000, 6'd0}},  // R1 disabled
    '{32'hFFFFFFFF, 32'h1, 4'h0, 16'h0,    7'h00, 24'h000003, 8'h00, {4'b1001, 6'd2}},  // R3 route
    '{32'hFFFFFFFF, 32'h0, 4'h0, 16'h0081, 7'h00, 24'h000025, 8'h00, {4'b1110, 6'd3}},  // R7 promote
    '{32'hFFFFFFFF, 32'h0, 4'h0, 16'h0003, 7'h00, 24'h000001, 8'h00, {4'b1000, 6'd1}},  // R7 code 11
    '{32'hFFFFFFFF, 32'h0, 4'h0, 16'h0,    7'h3F, 24'h800001, 8'h00, {4'b1100, 6'd1}},  // R8 top crit
    '{32'hFFFFFFFF, 32'h1, 4'h0, 16'h0,    7'h60, 24'h000001, 8'h00, {4'b0010, 6'd0}},  // R8 top smi
    '{32'hFFFFFFFE, 32'h0, 4'h0, 16'h0,    7'h20, 24'h000001, 8'h00, {4'b0000, 6'd0}}   // R1 top disabled
  };

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got irq/cint/smi/host=%b vec=%0d, expected %b vec=%0d",
               tag, act[9:6], act[5:0], exp[9:6], exp[5:0]);
    end
  endtask

  function automatic logic [9:0] outs();
    return {core_irq, core_cint, core_smi, host_irq, vec};
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_int = '0; irq_ext = '0; mchk_int = 1'b0; mchk_ext = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", outs(), 10'd0);
    checks++;
    if (core_mchk !== 1'b0) begin
      errors++; $display("FAIL R11 mchk: got %b expected 0", core_mchk);
    end

    // R11 / R1: default enables are clear, so requests are ignored
    irq_int = '1; irq_ext = '1;
    @(negedge clk); @(negedge clk);
    chk("R11 default disabled", outs(), 10'd0);

    // R2: machine checks pass with all sources disabled
    mchk_int = 1'b1;
    @(negedge clk);
    checks++;
    if (core_mchk !== 1'b1) begin
      errors++; $display("FAIL R2 int mchk: got %b expected 1", core_mchk);
    end
    mchk_int = 1'b0; mchk_ext = 1'b1;
    @(negedge clk);
    checks++;
    if (core_mchk !== 1'b1) begin
      errors++; $display("FAIL R2 ext mchk: got %b expected 1", core_mchk);
    end
    mchk_ext = 1'b0;
    irq_int = '0; irq_ext = '0;

    for (int i = 0; i < NROWS; i++) begin
      wr(3'd0, TBL[i].en);
      wr(3'd1, TBL[i].rt);
      wr(3'd2, {28'd0, TBL[i].sch});
      wr(3'd3, {16'd0, TBL[i].pr});
      wr(3'd4, {25'd0, TBL[i].top});
      irq_int = TBL[i].ii; irq_ext = TBL[i].ie;
      @(negedge clk); @(negedge clk);
      chk($sformatf("table row %0d", i), outs(), TBL[i].exp);
    end

    // R10: one-cycle latency and level release
    wr(3'd0, 32'hFFFFFFFF); wr(3'd1, 32'h0); wr(3'd2, 32'h0);
    wr(3'd3, 32'h0); wr(3'd4, 32'h0);
    irq_int = '0; irq_ext = '0;
    @(negedge clk);
    irq_ext = 8'h80;                      // s15
    @(negedge clk);
    chk("R10 rise after one edge", outs(), {4'b1000, 6'd16});
    irq_ext = 8'h00;
    @(negedge clk);
    chk("R10 release", outs(), 10'd0);

    // R9: core disabled, host still driven, core outputs low
    wr(3'd1, 32'h1);
    wr(3'd5, 32'h0);
    irq_int = 24'h000003; mchk_int = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 core disabled", outs(), {4'b0001, 6'd0});
    checks++;
    if (core_mchk !== 1'b0) begin
      errors++; $display("FAIL R9 mchk: got %b expected 0", core_mchk);
    end
    wr(3'd5, 32'h1);
    @(negedge clk);
    chk("R9 core re-enabled", outs(), {4'b1001, 6'd2});
    mchk_int = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule